// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block sits at the digital end of a two-channel sampling converter and owns its two parallel result buses. Every clock it accepts one corrected sample per channel, expressed in straight offset binary. It re-codes each sample into the format chosen by a static select pin and registers both channels together, so a word taken in at one rising edge is on the buses until the next rising edge.

Around that datapath sits a small controller. It turns an active-low output-enable pin into the three-state driver enables of both buses. It handles two low-power requests: a light sleep with a short recovery and a full shutdown with a longer one. It also raises a data-valid flag only once the recovery time of the mode just left has run out. The two recovery delays are set in nanoseconds and turned into clock counts from a clock-frequency parameter.

Top module: `dual_adc_outctl`

## Requirements
- R1: With `fmtTwos` low, a sample taken in at a rising edge while neither low-power request is set appears unchanged on its bus after that edge.
- R2: With `fmtTwos` high, the registered word is the sample with bit DATA_W-1 inverted and all other bits unchanged. Offset-binary 1000000000 becomes 0000000000, and 0000000000 becomes 1000000000.
- R3: Both channels load on the same edge with one register of latency. `dataValid` is high in every run cycle once any wake-up delay has expired.
- R4: `drvEnA` and `drvEnB` are both low while `oeN` is high and both high while `oeN` is low, in every mode.
- R5: While `pdReq` is high, neither bus changes, whatever the sample inputs do. With `oeN` low the drivers stay enabled, so the last word is still presented.
- R6: While `sleepReq` is high, neither bus changes and `dataValid` is low.
- R7: After the last edge with `sleepReq` high, `dataValid` stays low for SLEEP_CYC further edges and goes high on the next one. SLEEP_CYC is SLEEP_WAKE_NS scaled by CLK_MHZ and rounded up.
- R8: After the last edge with `pdReq` high, `dataValid` stays low for PD_CYC further edges and goes high on the next one. PD_CYC is PD_WAKE_NS scaled by CLK_MHZ and rounded up.
- R9: When `pdReq` and `sleepReq` are high together, shutdown wins. Both buses hold, and leaving that state costs PD_CYC edges.
- R10: A change on `fmtTwos` applies in full to the next registered word and never to part of a word.
- R11: While `rstN` is low, both buses read zero and `dataValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtTwos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oeN | input | 1 | Output enable, active low |
| sleepReq | input | 1 | Light sleep request |
| pdReq | input | 1 | Full shutdown request, wins over sleep |
| sampA | input | DATA_W | Channel A sample, offset binary |
| sampB | input | DATA_W | Channel B sample, offset binary |
| busA | output | DATA_W | Channel A registered output word |
| busB | output | DATA_W | Channel B registered output word |
| drvEnA | output | 1 | Three-state driver enable for busA |
| drvEnB | output | 1 | Three-state driver enable for busB |
| dataValid | output | 1 | Registered word is valid |

## Verification
The bench walks every input code through both formats on both channels at once, using mirrored codes. This exposes a re-coder that flips the wrong bit or that swaps or delays one channel. It toggles the format on every word, which catches a select that is sampled one cycle late. It counts edges after each low-power exit: a counter loaded with the wrong delay, or one that lets sleep override shutdown, raises `dataValid` on the wrong edge. It also moves the samples during shutdown and sleep, so a register that keeps loading shows a changed bus.

// File: rtl/adc_outctl_pkg.sv
package adc_outctl_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DOWN  = 2'd2
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new word this edge
    logic drive;  // three-state drivers on
  } strobe_t;

  // recovery time in ns -> clock count, rounded up, at least one
  function automatic int unsigned wakeCycles(input int unsigned clkMhz,
                                             input int unsigned ns);
    int unsigned c;
    c = (clkMhz * ns + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_outctl_ctrl.sv
module adc_outctl_ctrl
  import adc_outctl_pkg::*;
#(
  parameter int unsigned SLEEP_CYC = 23,
  parameter int unsigned PD_CYC    = 120
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    oeN,
  input  logic    sleepReq,
  input  logic    pdReq,
  output strobe_t strobe,
  output logic    dataValid
);

  localparam int unsigned MAX_CYC = (PD_CYC > SLEEP_CYC) ? PD_CYC : SLEEP_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SLEEP_LD = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] PD_LD    = CW'(PD_CYC);

  mode_e           mode;
  logic [CW-1:0]   wakeCnt;

  // shutdown has priority over sleep
  always_comb begin
    if (pdReq)         mode = MODE_DOWN;
    else if (sleepReq) mode = MODE_SLEEP;
    else               mode = MODE_RUN;
  end

  always_comb begin
    strobe.load  = (mode == MODE_RUN);
    strobe.drive = !oeN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt   <= '0;
      dataValid <= 1'b0;
    end else begin
      unique case (mode)
        MODE_DOWN: begin
          wakeCnt   <= PD_LD;
          dataValid <= 1'b0;
        end
        MODE_SLEEP: begin
          wakeCnt   <= SLEEP_LD;
          dataValid <= 1'b0;
        end
        default: begin
          if (wakeCnt != '0) begin
            wakeCnt   <= wakeCnt - 1'b1;
            dataValid <= 1'b0;
          end else begin
            dataValid <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_outctl_dpath.sv
module adc_outctl_dpath
  import adc_outctl_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              fmtTwos,
  input  logic [DATA_W-1:0] sampIn [NUM_CH],
  output logic [DATA_W-1:0] busOut [NUM_CH],
  output logic [NUM_CH-1:0] drvEn
);

  localparam int unsigned MSB = DATA_W - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] coded;

    // the two codings differ only in the top bit
    always_comb begin
      coded      = sampIn[ch];
      coded[MSB] = sampIn[ch][MSB] ^ fmtTwos;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            busOut[ch] <= '0;
      else if (strobe.load) busOut[ch] <= coded;
    end

    assign drvEn[ch] = strobe.drive;
  end

endmodule

// File: rtl/dual_adc_outctl.sv
module dual_adc_outctl
  import adc_outctl_pkg::*;
#(
  parameter int unsigned DATA_W        = 10,
  parameter int unsigned CLK_MHZ       = 80,
  parameter int unsigned SLEEP_WAKE_NS = 280,
  parameter int unsigned PD_WAKE_NS    = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fmtTwos,
  input  logic              oeN,
  input  logic              sleepReq,
  input  logic              pdReq,
  input  logic [DATA_W-1:0] sampA,
  input  logic [DATA_W-1:0] sampB,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic              drvEnA,
  output logic              drvEnB,
  output logic              dataValid
);

  localparam int unsigned SLEEP_CYC = wakeCycles(CLK_MHZ, SLEEP_WAKE_NS);
  localparam int unsigned PD_CYC    = wakeCycles(CLK_MHZ, PD_WAKE_NS);

  strobe_t           strobe;
  logic [DATA_W-1:0] sampArr [2];
  logic [DATA_W-1:0] busArr  [2];
  logic [1:0]        drvEn;

  assign sampArr[0] = sampA;
  assign sampArr[1] = sampB;
  assign busA       = busArr[0];
  assign busB       = busArr[1];
  assign drvEnA     = drvEn[0];
  assign drvEnB     = drvEn[1];

  adc_outctl_ctrl #(
    .SLEEP_CYC(SLEEP_CYC),
    .PD_CYC   (PD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .oeN      (oeN),
    .sleepReq (sleepReq),
    .pdReq    (pdReq),
    .strobe   (strobe),
    .dataValid(dataValid)
  );

  adc_outctl_dpath #(
    .DATA_W(DATA_W),
    .NUM_CH(2)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .fmtTwos(fmtTwos),
    .sampIn (sampArr),
    .busOut (busArr),
    .drvEn  (drvEn)
  );

endmodule

// File: rtl/dual_adc_outctl_chk.sv
module dual_adc_outctl_chk #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              fmtTwos,
  input logic              oeN,
  input logic              sleepReq,
  input logic              pdReq,
  input logic [DATA_W-1:0] sampA,
  input logic [DATA_W-1:0] sampB,
  input logic [DATA_W-1:0] busA,
  input logic [DATA_W-1:0] busB,
  input logic              drvEnA,
  input logic              drvEnB,
  input logic              dataValid
);

  // R4: drivers follow the enable pin in every mode
  assert_drv_follows_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (drvEnA == !oeN) && (drvEnB == !oeN));

  // R5, R6, R9: any low-power request freezes both buses
  assert_bus_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pdReq || sleepReq) |=> ($stable(busA) && $stable(busB)));

  // R1, R2, R10: run-mode word is the whole sample recoded by the select seen at that edge
  assert_word_coded_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pdReq && !sleepReq) |=>
      (busA == {$past(sampA[DATA_W-1] ^ fmtTwos), $past(sampA[DATA_W-2:0])}) &&
      (busB == {$past(sampB[DATA_W-1] ^ fmtTwos), $past(sampB[DATA_W-2:0])}));

  // R6: valid drops after any low-power cycle
  assert_valid_low_after_sleep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pdReq || sleepReq) |=> !dataValid);

  // R7: valid can only rise after a run-mode edge
  assert_valid_rise_in_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(!pdReq && !sleepReq));

endmodule

bind dual_adc_outctl dual_adc_outctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fmtTwos  (fmtTwos),
  .oeN      (oeN),
  .sleepReq (sleepReq),
  .pdReq    (pdReq),
  .sampA    (sampA),
  .sampB    (sampB),
  .busA     (busA),
  .busB     (busB),
  .drvEnA   (drvEnA),
  .drvEnB   (drvEnB),
  .dataValid(dataValid)
);

// File: tb/dual_adc_outctl_tb.sv
module dual_adc_outctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 10;
  localparam int SLEEP_D    = 3;   // 10 MHz, 300 ns
  localparam int PD_D       = 15;  // 10 MHz, 1500 ns

  logic          clk = 1'b0;
  logic          rstN, fmtTwos, oeN, sleepReq, pdReq;
  logic [DW-1:0] sampA, sampB, busA, busB;
  logic          drvEnA, drvEnB, dataValid;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_outctl #(
    .DATA_W(DW), .CLK_MHZ(10), .SLEEP_WAKE_NS(300), .PD_WAKE_NS(1500)
  ) u_dut (
    .clk(clk), .rstN(rstN), .fmtTwos(fmtTwos), .oeN(oeN),
    .sleepReq(sleepReq), .pdReq(pdReq), .sampA(sampA), .sampB(sampB),
    .busA(busA), .busB(busB), .drvEnA(drvEnA), .drvEnB(drvEnB),
    .dataValid(dataValid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int recode(input int v, input logic two);
    return two ? (v ^ (1 << (DW-1))) : v;
  endfunction

  // valid low for d edges after leaving low power, then high
  task automatic wakeCheck(input int d, input string req);
    for (int i = 0; i < d; i++) begin
      cyc();
      check(req, dataValid, 0);
    end
    cyc();
    check(req, dataValid, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 0; fmtTwos = 0; oeN = 0; sleepReq = 0; pdReq = 0;
    sampA = '0; sampB = '0;
    @(negedge clk); sampA = 10'h155; sampB = 10'h2AA;
    cyc(); cyc();
    check("R11 busA", busA, 0);
    check("R11 busB", busB, 0);
    check("R11 valid", dataValid, 0);
    rstN = 1;

    // R1 R2 R3: full code sweep, both formats, mirrored channels
    for (int f = 0; f < 2; f++) begin
      fmtTwos = f[0];
      for (int v = 0; v < (1 << DW); v++) begin
        sampA = v[DW-1:0];
        sampB = ~v[DW-1:0];
        cyc();
        check(f ? "R2 busA" : "R1 busA", busA, recode(v, f[0]));
        check("R3 busB", busB, recode((~v) & ((1 << DW) - 1), f[0]));
        check("R3 valid", dataValid, 1);
      end
    end

    // R2 named code points
    fmtTwos = 1; sampA = 10'h200; sampB = 10'h000; cyc();
    check("R2 zero", busA, 10'h000);
    check("R2 negfs", busB, 10'h200);

    // R10: toggle format on every word
    sampA = 10'h155; sampB = 10'h3F0;
    for (int i = 0; i < 8; i++) begin
      fmtTwos = i[0];
      cyc();
      check("R10 busA", busA, recode(10'h155, i[0]));
      check("R10 busB", busB, recode(10'h3F0, i[0]));
    end
    fmtTwos = 0;

    // R4: enable pin
    oeN = 1; sampA = 10'h0F0; cyc();
    check("R4 drvEnA off", drvEnA, 0);
    check("R4 drvEnB off", drvEnB, 0);
    check("R4 data still loads", busA, 10'h0F0);
    oeN = 0; cyc();
    check("R4 drvEnA on", drvEnA, 1);
    check("R4 drvEnB on", drvEnB, 1);

    // R5 R8: shutdown freezes, then long recovery
    sampA = 10'h2AA; sampB = 10'h055; cyc();
    pdReq = 1;
    for (int i = 0; i < 5; i++) begin
      sampA = 10'h011 + i[DW-1:0]; sampB = 10'h3C0 - i[DW-1:0];
      cyc();
      check("R5 busA hold", busA, 10'h2AA);
      check("R5 busB hold", busB, 10'h055);
      check("R5 drv", drvEnA, 1);
      check("R8 valid low", dataValid, 0);
    end
    oeN = 1; cyc();
    check("R4 drv off in pd", drvEnB, 0);
    oeN = 0;
    pdReq = 0;
    wakeCheck(PD_D, "R8 wake");

    // R6 R7: sleep holds, then short recovery
    sampA = 10'h123; sampB = 10'h321; cyc();
    sleepReq = 1;
    for (int i = 0; i < 4; i++) begin
      sampA = 10'h3FF; sampB = 10'h000;
      cyc();
      check("R6 busA hold", busA, 10'h123);
      check("R6 busB hold", busB, 10'h321);
      check("R6 valid low", dataValid, 0);
    end
    sleepReq = 0;
    wakeCheck(SLEEP_D, "R7 wake");

    // R9: both requests, shutdown delay wins
    sampA = 10'h0AA; cyc();
    sleepReq = 1; pdReq = 1;
    for (int i = 0; i < 3; i++) begin
      sampA = 10'h001;
      cyc();
      check("R9 hold", busA, 10'h0AA);
    end
    sleepReq = 0; pdReq = 0;
    wakeCheck(PD_D, "R9 wake");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule